// File: doc/BRIEF.md
# Command Packet Dispatcher with Seconds Clock

This block sits behind a byte-level link receiver and interprets one complete packet at a time. The first byte of a packet selects its class. Class 0 packets are meant for an attached peripheral bus, so the dispatcher only raises a one-cycle forward strobe for them. Class 1 packets carry a local command: the second byte is the opcode and the remaining bytes are its arguments. Every other class, and any packet too short to hold its class byte (or, for class 1, its opcode), is dropped without a reply.

For a local command the block checks the exact argument count the opcode needs and runs the command. It then returns a reply packet in a 16-byte buffer with a length, valid one cycle after the packet is presented. The commands drive an autopoll enable, a poll period, a 16-bit device mask, and one-cycle power-down and system-reset strobes. A 32-bit seconds counter advances on an external one-second tick. Its count starts from midnight, 1 January 1904, so the default reset value is 2082844800, the count at the start of 1970. A command can read the counter or load it.

Top module: `ctl_pkt_dispatch`

## Requirements
- R1: After reset, rsp_valid, bus_fwd, pwr_down and sys_reset are 0, apoll_en is 0, poll_rate is 20, dev_mask is 16'hFFFF, and the seconds counter holds RTC_INIT.
- R2: A packet with length at least 1 and class byte 0 pulses bus_fwd for exactly the cycle after it is presented, produces no reply and changes no setting.
- R3: A packet of length 0, a packet whose class byte is 2 or higher, and a class 1 packet of length 1 produce no reply, no strobe and no change of setting.
- R4: A command with a known opcode and a correct argument count is answered with rsp_len 3 and bytes 1, 0, opcode (byte 0 first, byte i at rsp_data[8i+7:8i]); all unused bytes are 0 and rsp_valid is high for one cycle, the cycle after the packet.
- R5: A known opcode with the wrong argument count is answered with rsp_len 4 and bytes 2, 8'h05, 1, opcode, and has no other effect.
- R6: An opcode not in the command set is answered with rsp_len 4 and bytes 2, 8'h02, 1, opcode, and has no other effect.
- R7: The autopoll command (OPC_APOLL) takes 1 argument; apoll_en becomes 1 if it is nonzero and 0 if it is zero.
- R8: The set-rate command (OPC_RATE) takes 1 argument that becomes poll_rate; an argument of 0 is rejected with the R5 error and poll_rate keeps its value.
- R9: The device-list command (OPC_DEVLIST) takes 2 arguments; dev_mask becomes {first argument, second argument}.
- R10: The power-down (OPC_PWRDN) and reset (OPC_SYSRST) commands take 0 arguments and pulse pwr_down or sys_reset for one cycle with the reply; the file-server-flag (OPC_FSFLAG) and power-message (OPC_PWRMSG) commands take 1 argument and are acknowledged with no other effect.
- R11: The get-time command (OPC_GETTIME) takes 0 arguments and replies with rsp_len 7: bytes 1, 0, opcode, then the seconds counter value as it was before that clock edge, most significant byte first.
- R12: The seconds counter increments by one on every clock edge with sec_tick high; the set-time command (OPC_SETTIME, 4 arguments, most significant first) loads it instead and takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pkt_valid | input | 1 | A packet is present this cycle |
| pkt_len | input | LEN_W (4) | Packet length in bytes |
| pkt_data | input | RX_BYTES*8 (64) | Packet bytes, byte 0 in bits 7:0 |
| sec_tick | input | 1 | One-second tick |
| rsp_valid | output | 1 | Reply valid for one cycle |
| rsp_len | output | RSP_LW (5) | Reply length in bytes |
| rsp_data | output | RSP_BYTES*8 (128) | Reply bytes, byte 0 in bits 7:0 |
| bus_fwd | output | 1 | Class 0 packet forward strobe |
| pwr_down | output | 1 | Power-down strobe |
| sys_reset | output | 1 | System reset strobe |
| apoll_en | output | 1 | Autopoll enable |
| poll_rate | output | 8 | Poll period setting |
| dev_mask | output | 16 | Polled device mask |

## Verification
The bench goes after argument counts that are one off from correct. A design that compared loosely there would run the command and return a success header instead of the 8'h05 error. It sends a zero set-rate argument: a design missing that check would store a period of 0. It raises a tick in the same cycle as set-time: a design with the wrong priority would return the loaded value plus one on the next read. It also checks for replies on dropped classes, short packets and class 0 packets, and checks that a read of the counter returns its bytes most significant first. A reversed byte order or a stale counter value shows up as a byte mismatch in the reply.

// File: rtl/ctl_pkt_pkg.sv
package ctl_pkt_pkg;

  localparam logic [7:0] CLS_BUS = 8'd0;
  localparam logic [7:0] CLS_CMD = 8'd1;
  localparam logic [7:0] CLS_ERR = 8'd2;

  localparam logic [7:0] ERR_BAD_ARGS = 8'h05;
  localparam logic [7:0] ERR_UNKNOWN  = 8'h02;

  localparam int NUM_CMDS = 9;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_APOLL,
    OP_RATE,
    OP_DEVLIST,
    OP_PWRDN,
    OP_SYSRST,
    OP_FSFLAG,
    OP_PWRMSG,
    OP_GETTIME,
    OP_SETTIME
  } op_e;

  typedef struct packed {
    op_e  op;
    logic known;
    logic args_ok;
  } decode_t;

endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
  import ctl_pkt_pkg::*;
#(
  parameter int         LEN_W       = 4,
  parameter logic [7:0] OPC_APOLL   = 8'h01,
  parameter logic [7:0] OPC_RATE    = 8'h14,
  parameter logic [7:0] OPC_DEVLIST = 8'h19,
  parameter logic [7:0] OPC_PWRDN   = 8'h0A,
  parameter logic [7:0] OPC_SYSRST  = 8'h11,
  parameter logic [7:0] OPC_FSFLAG  = 8'h13,
  parameter logic [7:0] OPC_PWRMSG  = 8'h21,
  parameter logic [7:0] OPC_GETTIME = 8'h03,
  parameter logic [7:0] OPC_SETTIME = 8'h09
) (
  input  logic [7:0]       opcode,
  input  logic [LEN_W-1:0] arg_cnt,
  input  logic [7:0]       arg0,
  output decode_t          dec
);

  localparam logic [7:0] OPC_TBL [NUM_CMDS] = '{
    OPC_APOLL, OPC_RATE, OPC_DEVLIST, OPC_PWRDN, OPC_SYSRST,
    OPC_FSFLAG, OPC_PWRMSG, OPC_GETTIME, OPC_SETTIME
  };
  localparam op_e OP_TBL [NUM_CMDS] = '{
    OP_APOLL, OP_RATE, OP_DEVLIST, OP_PWRDN, OP_SYSRST,
    OP_FSFLAG, OP_PWRMSG, OP_GETTIME, OP_SETTIME
  };
  localparam int ARGS_TBL [NUM_CMDS] = '{1, 1, 2, 0, 0, 1, 1, 0, 4};

  always_comb begin
    dec.op      = OP_NONE;
    dec.known   = 1'b0;
    dec.args_ok = 1'b0;
    for (int i = 0; i < NUM_CMDS; i++) begin
      if (opcode == OPC_TBL[i]) begin
        dec.op      = OP_TBL[i];
        dec.known   = 1'b1;
        dec.args_ok = (arg_cnt == LEN_W'(ARGS_TBL[i]));
      end
    end
    // a zero poll period is not accepted
    if (dec.op == OP_RATE && arg0 == 8'd0) begin
      dec.args_ok = 1'b0;
    end
  end

endmodule

// File: rtl/sec_counter.sv
module sec_counter #(
  parameter int          W    = 32,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] sec
);

  logic [W-1:0] sec_q, sec_d;

  always_comb begin
    sec_d = sec_q;
    if (load_en) begin
      sec_d = load_val;
    end else if (tick) begin
      sec_d = sec_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= INIT;
    end else if (load_en || tick) begin
      sec_q <= sec_d;
    end
  end

  assign sec = sec_q;

  // R12
  tick_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load_en) |=> (sec_q == $past(sec_q) + W'(1)));

  // R12
  load_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (sec_q == $past(load_val)));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load_en) |=> $stable(sec_q));

endmodule

// File: rtl/reply_build.sv
module reply_build
  import ctl_pkt_pkg::*;
#(
  parameter int RSP_BYTES = 16,
  parameter int RSP_LW    = 5
) (
  input  decode_t                 dec,
  input  logic [7:0]              opcode,
  input  logic [31:0]             sec,
  output logic [RSP_LW-1:0]       len,
  output logic [RSP_BYTES*8-1:0]  bytes
);

  always_comb begin
    bytes = '0;
    len   = RSP_LW'(4);
    bytes[7:0]   = CLS_ERR;
    bytes[23:16] = CLS_CMD;
    bytes[31:24] = opcode;
    if (!dec.known) begin
      bytes[15:8] = ERR_UNKNOWN;
    end else if (!dec.args_ok) begin
      bytes[15:8] = ERR_BAD_ARGS;
    end else begin
      bytes[7:0]   = CLS_CMD;
      bytes[15:8]  = 8'd0;
      bytes[23:16] = opcode;
      bytes[31:24] = 8'd0;
      len          = RSP_LW'(3);
      if (dec.op == OP_GETTIME) begin
        bytes[31:24] = sec[31:24];
        bytes[39:32] = sec[23:16];
        bytes[47:40] = sec[15:8];
        bytes[55:48] = sec[7:0];
        len          = RSP_LW'(7);
      end
    end
  end

endmodule

// File: rtl/ctl_pkt_dispatch.sv
module ctl_pkt_dispatch
  import ctl_pkt_pkg::*;
#(
  parameter int          RX_BYTES    = 8,
  parameter int          RSP_BYTES   = 16,
  parameter logic [31:0] RTC_INIT    = 32'd2082844800,
  parameter logic [7:0]  RATE_INIT   = 8'd20,
  parameter logic [15:0] MASK_INIT   = 16'hFFFF,
  parameter logic [7:0]  OPC_APOLL   = 8'h01,
  parameter logic [7:0]  OPC_RATE    = 8'h14,
  parameter logic [7:0]  OPC_DEVLIST = 8'h19,
  parameter logic [7:0]  OPC_PWRDN   = 8'h0A,
  parameter logic [7:0]  OPC_SYSRST  = 8'h11,
  parameter logic [7:0]  OPC_FSFLAG  = 8'h13,
  parameter logic [7:0]  OPC_PWRMSG  = 8'h21,
  parameter logic [7:0]  OPC_GETTIME = 8'h03,
  parameter logic [7:0]  OPC_SETTIME = 8'h09,
  localparam int         LEN_W       = $clog2(RX_BYTES + 1),
  localparam int         RSP_LW      = $clog2(RSP_BYTES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pkt_valid,
  input  logic [LEN_W-1:0]        pkt_len,
  input  logic [RX_BYTES*8-1:0]   pkt_data,
  input  logic                    sec_tick,
  output logic                    rsp_valid,
  output logic [RSP_LW-1:0]       rsp_len,
  output logic [RSP_BYTES*8-1:0]  rsp_data,
  output logic                    bus_fwd,
  output logic                    pwr_down,
  output logic                    sys_reset,
  output logic                    apoll_en,
  output logic [7:0]              poll_rate,
  output logic [15:0]             dev_mask
);

  localparam int PAD_BYTES = (RX_BYTES < 6) ? 6 : RX_BYTES;

  // asynchronous assertion, synchronous release
  logic rst_meta, rst_n_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta  <= 1'b0;
      rst_n_int <= 1'b0;
    end else begin
      rst_meta  <= 1'b1;
      rst_n_int <= rst_meta;
    end
  end

  logic [PAD_BYTES*8-1:0] pad;
  logic [7:0]             cls_b, opc_b, a0, a1, a2, a3;
  logic [LEN_W-1:0]       arg_cnt;
  logic                   is_cmd, is_bus, run;
  decode_t                dec;
  logic [31:0]            sec;
  logic [RSP_LW-1:0]      bld_len;
  logic [RSP_BYTES*8-1:0] bld_bytes;

  assign pad     = (PAD_BYTES*8)'(pkt_data);
  assign cls_b   = pad[7:0];
  assign opc_b   = pad[15:8];
  assign a0      = pad[23:16];
  assign a1      = pad[31:24];
  assign a2      = pad[39:32];
  assign a3      = pad[47:40];
  assign arg_cnt = pkt_len - LEN_W'(2);

  assign is_bus = pkt_valid && (pkt_len != '0) && (cls_b == CLS_BUS);
  assign is_cmd = pkt_valid && (pkt_len >= LEN_W'(2)) && (cls_b == CLS_CMD);
  assign run    = is_cmd && dec.known && dec.args_ok;

  cmd_decode #(
    .LEN_W(LEN_W),
    .OPC_APOLL(OPC_APOLL), .OPC_RATE(OPC_RATE), .OPC_DEVLIST(OPC_DEVLIST),
    .OPC_PWRDN(OPC_PWRDN), .OPC_SYSRST(OPC_SYSRST), .OPC_FSFLAG(OPC_FSFLAG),
    .OPC_PWRMSG(OPC_PWRMSG), .OPC_GETTIME(OPC_GETTIME), .OPC_SETTIME(OPC_SETTIME)
  ) u_decode (
    .opcode (opc_b),
    .arg_cnt(arg_cnt),
    .arg0   (a0),
    .dec    (dec)
  );

  sec_counter #(.W(32), .INIT(RTC_INIT)) u_sec (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .tick    (sec_tick),
    .load_en (run && dec.op == OP_SETTIME),
    .load_val({a0, a1, a2, a3}),
    .sec     (sec)
  );

  reply_build #(.RSP_BYTES(RSP_BYTES), .RSP_LW(RSP_LW)) u_reply (
    .dec   (dec),
    .opcode(opc_b),
    .sec   (sec),
    .len   (bld_len),
    .bytes (bld_bytes)
  );

  // next-state logic
  logic        apoll_d, pwr_d, srst_d;
  logic [7:0]  rate_d;
  logic [15:0] mask_d;

  always_comb begin
    apoll_d = apoll_en;
    rate_d  = poll_rate;
    mask_d  = dev_mask;
    pwr_d   = 1'b0;
    srst_d  = 1'b0;
    if (run) begin
      unique case (dec.op)
        OP_APOLL:   apoll_d = (a0 != 8'd0);
        OP_RATE:    rate_d  = a0;
        OP_DEVLIST: mask_d  = {a0, a1};
        OP_PWRDN:   pwr_d   = 1'b1;
        OP_SYSRST:  srst_d  = 1'b1;
        default:    ;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      rsp_valid <= 1'b0;
      bus_fwd   <= 1'b0;
      pwr_down  <= 1'b0;
      sys_reset <= 1'b0;
      apoll_en  <= 1'b0;
      poll_rate <= RATE_INIT;
      dev_mask  <= MASK_INIT;
    end else begin
      rsp_valid <= is_cmd;
      bus_fwd   <= is_bus;
      pwr_down  <= pwr_d;
      sys_reset <= srst_d;
      if (run) begin
        apoll_en  <= apoll_d;
        poll_rate <= rate_d;
        dev_mask  <= mask_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      rsp_len  <= '0;
      rsp_data <= '0;
    end else if (is_cmd) begin
      rsp_len  <= bld_len;
      rsp_data <= bld_bytes;
    end
  end

  // R2
  bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    bus_fwd |-> !rsp_valid);

  // R10
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (pwr_down || sys_reset) |-> (rsp_valid && $past(pkt_valid)));

  // R8
  rate_nz_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    poll_rate != 8'd0);

  // R7
  apoll_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    !$past(pkt_valid) |-> $stable(apoll_en));

  // R4
  rsp_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    rsp_valid |-> ((rsp_data[7:0] == CLS_CMD && rsp_len >= RSP_LW'(3)) ||
                   (rsp_data[7:0] == CLS_ERR && rsp_len == RSP_LW'(4))));

endmodule

// File: tb/tb_ctl_pkt_dispatch.sv
`timescale 1ns/1ps
module tb_ctl_pkt_dispatch;

  localparam logic [31:0] RTC0 = 32'd2082844800;
  localparam logic [7:0] C_APOLL = 8'h01, C_RATE = 8'h14, C_DEV = 8'h19,
                         C_PWR = 8'h0A, C_RST = 8'h11, C_FS = 8'h13,
                         C_PMSG = 8'h21, C_GET = 8'h03, C_SET = 8'h09;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         pkt_valid;
  logic [3:0]   pkt_len;
  logic [63:0]  pkt_data;
  logic         sec_tick;
  logic         rsp_valid;
  logic [4:0]   rsp_len;
  logic [127:0] rsp_data;
  logic         bus_fwd, pwr_down, sys_reset, apoll_en;
  logic [7:0]   poll_rate;
  logic [15:0]  dev_mask;

  always #2 clk = ~clk;

  ctl_pkt_dispatch #(
    .RX_BYTES(8), .RSP_BYTES(16), .RTC_INIT(RTC0),
    .OPC_APOLL(C_APOLL), .OPC_RATE(C_RATE), .OPC_DEVLIST(C_DEV),
    .OPC_PWRDN(C_PWR), .OPC_SYSRST(C_RST), .OPC_FSFLAG(C_FS),
    .OPC_PWRMSG(C_PMSG), .OPC_GETTIME(C_GET), .OPC_SETTIME(C_SET)
  ) dut (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_len(pkt_len),
    .pkt_data(pkt_data), .sec_tick(sec_tick), .rsp_valid(rsp_valid),
    .rsp_len(rsp_len), .rsp_data(rsp_data), .bus_fwd(bus_fwd),
    .pwr_down(pwr_down), .sys_reset(sys_reset), .apoll_en(apoll_en),
    .poll_rate(poll_rate), .dev_mask(dev_mask)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // bench model state
  logic [31:0] m_sec;
  logic        m_apoll;
  logic [7:0]  m_rate;
  logic [15:0] m_mask;

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int args_needed(input logic [7:0] c);
    case (c)
      C_APOLL, C_RATE, C_FS, C_PMSG: return 1;
      C_DEV:                         return 2;
      C_PWR, C_RST, C_GET:           return 0;
      C_SET:                         return 4;
      default:                       return -1;
    endcase
  endfunction

  // one packet (or idle when pv=0) plus optional tick, then compare
  task automatic xfer(input bit pv, input int len, input logic [7:0] b[8], input bit tick);
    bit           e_valid = 1'b0, e_bus = 1'b0, e_pwr = 1'b0, e_rst = 1'b0;
    int           e_len = 0;
    logic [127:0] e_data = '0;
    string        tag = "R3";
    int           need;
    int           ac;
    bit           did_set = 1'b0;
    for (int i = 0; i < 8; i++) pkt_data[i*8 +: 8] = b[i];
    pkt_valid = pv;
    pkt_len   = 4'(len);
    sec_tick  = tick;
    if (pv && len >= 1 && b[0] == 8'd0) begin
      e_bus = 1'b1; tag = "R2";
    end else if (pv && len >= 2 && b[0] == 8'd1) begin
      e_valid = 1'b1;
      need = args_needed(b[1]);
      ac   = len - 2;
      if (need < 0) begin
        e_len = 4; e_data[31:0] = {b[1], 8'd1, 8'h02, 8'd2}; tag = "R6";
      end else if (ac != need || (b[1] == C_RATE && b[2] == 8'd0)) begin
        e_len = 4; e_data[31:0] = {b[1], 8'd1, 8'h05, 8'd2};
        tag = (b[1] == C_RATE) ? "R8" : "R5";
      end else begin
        e_len = 3; e_data[23:0] = {b[1], 8'd0, 8'd1}; tag = "R4";
        case (b[1])
          C_APOLL: begin m_apoll = (b[2] != 0); tag = "R7"; end
          C_RATE:  begin m_rate = b[2]; tag = "R8"; end
          C_DEV:   begin m_mask = {b[2], b[3]}; tag = "R9"; end
          C_PWR:   begin e_pwr = 1'b1; tag = "R10"; end
          C_RST:   begin e_rst = 1'b1; tag = "R10"; end
          C_FS, C_PMSG: tag = "R10";
          C_GET: begin
            e_len = 7;
            e_data[55:24] = {m_sec[7:0], m_sec[15:8], m_sec[23:16], m_sec[31:24]};
            tag = "R11";
          end
          C_SET: begin
            m_sec = {b[2], b[3], b[4], b[5]}; did_set = 1'b1; tag = "R12";
          end
          default: ;
        endcase
      end
    end
    if (!did_set && tick) m_sec = m_sec + 32'd1;
    @(negedge clk);
    check(rsp_valid == e_valid, {tag, " rsp_valid"}, 128'(rsp_valid), 128'(e_valid));
    if (e_valid) begin
      check(rsp_len == 5'(e_len), {tag, " rsp_len"}, 128'(rsp_len), 128'(e_len));
      check(rsp_data == e_data, {tag, " rsp_data"}, rsp_data, e_data);
    end
    check(bus_fwd == e_bus, "R2 bus_fwd", 128'(bus_fwd), 128'(e_bus));
    check(pwr_down == e_pwr && sys_reset == e_rst, "R10 strobes",
          128'({pwr_down, sys_reset}), 128'({e_pwr, e_rst}));
    check(apoll_en == m_apoll, "R7 apoll_en", 128'(apoll_en), 128'(m_apoll));
    check(poll_rate == m_rate, "R8 poll_rate", 128'(poll_rate), 128'(m_rate));
    check(dev_mask == m_mask, "R9 dev_mask", 128'(dev_mask), 128'(m_mask));
    pkt_valid = 1'b0;
    sec_tick  = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] c, input int nargs, input logic [7:0] a0,
                     input logic [7:0] a1, input logic [7:0] a2, input logic [7:0] a3,
                     input bit tick);
    logic [7:0] b[8];
    b = '{8'd1, c, a0, a1, a2, a3, 8'd0, 8'd0};
    xfer(1'b1, nargs + 2, b, tick);
  endtask

  initial begin
    logic [7:0] b[8];
    logic [7:0] ops[10];
    void'($urandom(32'd4242));
    ops = '{C_APOLL, C_RATE, C_DEV, C_PWR, C_RST, C_FS, C_PMSG, C_GET, C_SET, 8'h7E};
    rst_n = 1'b0; pkt_valid = 1'b0; pkt_len = '0; pkt_data = '0; sec_tick = 1'b0;
    m_sec = RTC0; m_apoll = 1'b0; m_rate = 8'd20; m_mask = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check(!rsp_valid && !bus_fwd && !pwr_down && !sys_reset, "R1 strobes idle",
          128'({rsp_valid, bus_fwd, pwr_down, sys_reset}), 128'(0));
    check(!apoll_en && poll_rate == 8'd20 && dev_mask == 16'hFFFF, "R1 settings",
          128'({apoll_en, poll_rate, dev_mask}), 128'({1'b0, 8'd20, 16'hFFFF}));
    cmd(C_GET, 0, 0, 0, 0, 0, 1'b0);                        // R1 / R11: initial count

    // directed corners
    b = '{8'd0, 8'h55, 8'h66, 0, 0, 0, 0, 0}; xfer(1'b1, 3, b, 1'b0);   // R2
    b = '{8'd3, C_PWR, 0, 0, 0, 0, 0, 0};     xfer(1'b1, 2, b, 1'b0);   // R3
    b = '{8'd1, C_PWR, 0, 0, 0, 0, 0, 0};     xfer(1'b1, 1, b, 1'b0);   // R3
    b = '{8'd0, 0, 0, 0, 0, 0, 0, 0};         xfer(1'b1, 0, b, 1'b0);   // R3
    cmd(8'h7E, 0, 0, 0, 0, 0, 1'b0);                        // R6
    cmd(C_APOLL, 2, 8'h01, 0, 0, 0, 1'b0);                  // R5 one too many
    cmd(C_SET, 3, 1, 2, 3, 0, 1'b0);                        // R5 one too few
    cmd(C_APOLL, 1, 8'h80, 0, 0, 0, 1'b0);                  // R7 enable
    cmd(C_APOLL, 1, 8'h00, 0, 0, 0, 1'b0);                  // R7 disable
    cmd(C_RATE, 1, 8'd0, 0, 0, 0, 1'b0);                    // R8 zero rejected
    cmd(C_RATE, 1, 8'd7, 0, 0, 0, 1'b0);                    // R8
    cmd(C_DEV, 2, 8'hA5, 8'h3C, 0, 0, 1'b0);                // R9
    cmd(C_PWR, 0, 0, 0, 0, 0, 1'b0);                        // R10
    cmd(C_RST, 0, 0, 0, 0, 0, 1'b0);                        // R10
    cmd(C_FS, 1, 8'h01, 0, 0, 0, 1'b0);                     // R10
    cmd(C_PMSG, 1, 8'h02, 0, 0, 0, 1'b0);                   // R10
    b = '{0, 0, 0, 0, 0, 0, 0, 0};
    xfer(1'b0, 0, b, 1'b1);                                 // R12 tick
    xfer(1'b0, 0, b, 1'b1);
    cmd(C_GET, 0, 0, 0, 0, 0, 1'b0);                        // R11
    cmd(C_SET, 4, 8'hFF, 8'hFF, 8'hFF, 8'hFE, 1'b1);        // R12 load beats tick
    cmd(C_GET, 0, 0, 0, 0, 0, 1'b1);                        // R12 read then tick
    xfer(1'b0, 0, b, 1'b1);                                 // R12 wrap
    cmd(C_GET, 0, 0, 0, 0, 0, 1'b0);

    // random mix
    for (int it = 0; it < 600; it++) begin
      int r;
      int len;
      r = $urandom_range(0, 9);
      b[0] = (r < 7) ? 8'd1 : ((r == 7) ? 8'd0 : 8'($urandom_range(2, 255)));
      b[1] = ops[$urandom_range(0, 9)];
      for (int k = 2; k < 8; k++) b[k] = ($urandom_range(0, 3) == 0) ? 8'd0 : 8'($urandom);
      len = args_needed(b[1]) + 2;
      if (len < 2 || $urandom_range(0, 3) == 0) len = $urandom_range(0, 8);
      xfer($urandom_range(0, 4) != 0, len, b, $urandom_range(0, 3) == 0);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule